// File: doc/BRIEF.md
# ADC Calibration and Conversion Sequencer

This block is the control state machine of a successive-approximation converter. After power-up it does not convert on the first convert-start pulse: that pulse opens a settling window, counted in clock cycles, long enough for an on-chip reference to stabilise. The pulse after the window ends launches an automatic full self-calibration, and from then on every convert-start pulse begins a normal conversion. Software can also ask for any of four calibration kinds at any idle moment by writing the control register with its start-calibration bit set.

The analog trim engine and the conversion datapath sit outside the block. Toward the trim engine the sequencer presents a two-bit calibration code and a one-cycle start strobe for each calibration phase. Toward the datapath it issues a one-cycle conversion-start strobe and waits for a conversion-done pulse. A single busy flag covers every interval, and all trigger inputs arriving while it is high are dropped. Every calibration phase is modelled as a timed busy interval whose length comes from a parameter.

Top module: `adc_cal_seq`

## Requirements
- R1: While reset is asserted and right after release, busy, both strobes and the calibration code are all zero.
- R2: The first convert-start after reset produces no conversion strobe and holds busy high for exactly SETTLE_CYC cycles, starting on the clock edge that samples the pulse.
- R3: A convert-start pulse arriving while busy is high has no effect: no strobe is produced and the busy interval keeps its length.
- R4: The first convert-start after the settling window raises the calibration strobe with code 2'b00 (full) and holds busy for exactly AUTO_CYC cycles.
- R5: Once initialisation is done, a convert-start pulse gives one conversion strobe in the first busy cycle; busy stays high until the clock edge that samples conversion-done, then falls.
- R6: Any control-register write made before the automatic calibration starts (before the first pulse or during the settling window) cancels it, so the pulse after the window converts; the settling window keeps its full length.
- R7: A register write during the automatic calibration does not shorten it; busy stays high for all AUTO_CYC cycles.
- R8: A register write with the start-calibration bit at 1 while idle begins a calibration on the next edge; the two-bit type field selects 2'b00 full (FULL_CYC), 2'b10 offset only (OFF_CYC), 2'b11 gain only (GAIN_CYC). A write with the bit at 0 starts nothing.
- R9: Type 2'b01 (gain plus offset) runs a gain phase of GAIN_CYC cycles reported as code 2'b11, then an offset phase of OFF_CYC cycles reported as 2'b10, each opened by its own calibration strobe, with busy held continuously for the sum.
- R10: A start-calibration write arriving while busy is high is ignored.
- R11: When an idle cycle carries both a start-calibration write and a convert-start pulse, the calibration is taken and the pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| conv_start_i | input | 1 | Convert-start pulse, one cycle |
| reg_wr_i | input | 1 | Control-register write strobe |
| reg_stcal_i | input | 1 | Start-calibration bit of the written value |
| reg_caltype_i | input | 2 | Calibration-type field of the written value |
| conv_done_i | input | 1 | Conversion finished, from the datapath |
| busy_o | output | 1 | High during settling, calibration and conversion |
| cal_code_o | output | 2 | Code of the running calibration phase, 2'b00 otherwise |
| cal_go_o | output | 1 | One-cycle start strobe for each calibration phase |
| conv_go_o | output | 1 | One-cycle conversion-start strobe |

## Verification
The properties assume that convert-start and register writes are single-cycle pulses, that conversion-done is pulsed only while a conversion is running, and that every duration parameter is at least one cycle. The stimulus raises each trigger for exactly one cycle, drives conversion-done once per conversion after a chosen latency, and keeps the durations small but pairwise distinct so that a swapped phase shows up as a wrong busy length. Triggers that must be dropped are placed well inside busy intervals, and the simultaneous-trigger case is driven in a single idle cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    CK_FULL     = 2'b00,
    CK_GAIN_OFF = 2'b01,
    CK_OFFSET   = 2'b10,
    CK_GAIN     = 2'b11
  } cal_kind_e;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_SETTLE,
    ST_ARMED,
    ST_AUTOCAL,
    ST_READY,
    ST_USERCAL,
    ST_CONVERT
  } seq_state_e;

  typedef enum logic [2:0] {
    IV_SETTLE,
    IV_AUTO,
    IV_FULL,
    IV_OFFSET,
    IV_GAIN
  } interval_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_interval_rom.sv
module seq_interval_rom
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 128000,
  parameter int unsigned AUTO_CYC   = 128000,
  parameter int unsigned FULL_CYC   = 125000,
  parameter int unsigned OFF_CYC    = 13880,
  parameter int unsigned GAIN_CYC   = 13880,
  parameter int unsigned W          = 17
) (
  input  interval_e      sel_i,
  output logic [W-1:0]   cycles_o
);

  always_comb begin
    case (sel_i)
      IV_SETTLE: cycles_o = W'(SETTLE_CYC);
      IV_AUTO:   cycles_o = W'(AUTO_CYC);
      IV_FULL:   cycles_o = W'(FULL_CYC);
      IV_OFFSET: cycles_o = W'(OFF_CYC);
      IV_GAIN:   cycles_o = W'(GAIN_CYC);
      default:   cycles_o = W'(SETTLE_CYC);
    endcase
  end

endmodule

// File: rtl/seq_interval_timer.sv
module seq_interval_timer #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         run_q, run_d;
  logic         cnt_en;

  // The final cycle of an interval is the one where the count sits at zero.
  assign expire_o = run_q && (cnt_q == '0);
  assign cnt_en   = load_i || (run_q && (cnt_q != '0));

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = load_val_i - {{(W-1){1'b0}}, 1'b1};
      run_d = 1'b1;
    end else begin
      if (run_q && (cnt_q != '0)) cnt_d = cnt_q - {{(W-1){1'b0}}, 1'b1};
      if (expire_o)               run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_start_i,
  input  logic       reg_wr_i,
  input  logic       reg_stcal_i,
  input  cal_kind_e  reg_kind_i,
  input  logic       conv_done_i,
  input  logic       expire_i,
  output logic       load_o,
  output interval_e  interval_o,
  output logic       busy_o,
  output logic [1:0] cal_code_o,
  output logic       cal_go_o,
  output logic       conv_go_o
);

  seq_state_e state_q, state_d;
  cal_kind_e  code_q, code_d;
  logic       skip_q, skip_d;
  logic       second_q, second_d;
  logic       cal_go_q, cal_go_d;
  logic       conv_go_q, conv_go_d;

  // Decode of a requested calibration into its first phase.
  interval_e  user_iv;
  cal_kind_e  user_code;
  logic       user_two_phase;
  logic       cal_req;

  assign cal_req = reg_wr_i && reg_stcal_i;

  always_comb begin
    user_two_phase = 1'b0;
    case (reg_kind_i)
      CK_FULL:     begin user_iv = IV_FULL;   user_code = CK_FULL;   end
      CK_GAIN_OFF: begin user_iv = IV_GAIN;   user_code = CK_GAIN;   user_two_phase = 1'b1; end
      CK_OFFSET:   begin user_iv = IV_OFFSET; user_code = CK_OFFSET; end
      default:     begin user_iv = IV_GAIN;   user_code = CK_GAIN;   end
    endcase
  end

  always_comb begin
    state_d    = state_q;
    code_d     = code_q;
    skip_d     = skip_q;
    second_d   = second_q;
    cal_go_d   = 1'b0;
    conv_go_d  = 1'b0;
    load_o     = 1'b0;
    interval_o = IV_SETTLE;
    case (state_q)
      ST_POWERUP: begin
        if (reg_wr_i) skip_d = 1'b1;
        if (conv_start_i) begin
          state_d    = ST_SETTLE;
          load_o     = 1'b1;
          interval_o = IV_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (reg_wr_i) skip_d = 1'b1;
        if (expire_i) state_d = ST_ARMED;
      end
      ST_ARMED: begin
        if (cal_req) begin
          state_d    = ST_USERCAL;
          load_o     = 1'b1;
          interval_o = user_iv;
          code_d     = user_code;
          second_d   = user_two_phase;
          cal_go_d   = 1'b1;
          skip_d     = 1'b1;
        end else begin
          if (reg_wr_i) skip_d = 1'b1;
          if (conv_start_i) begin
            if (skip_q || reg_wr_i) begin
              state_d   = ST_CONVERT;
              conv_go_d = 1'b1;
            end else begin
              state_d    = ST_AUTOCAL;
              load_o     = 1'b1;
              interval_o = IV_AUTO;
              code_d     = CK_FULL;
              cal_go_d   = 1'b1;
            end
          end
        end
      end
      ST_AUTOCAL: begin
        if (expire_i) state_d = ST_READY;
      end
      ST_READY: begin
        if (cal_req) begin
          state_d    = ST_USERCAL;
          load_o     = 1'b1;
          interval_o = user_iv;
          code_d     = user_code;
          second_d   = user_two_phase;
          cal_go_d   = 1'b1;
        end else if (conv_start_i) begin
          state_d   = ST_CONVERT;
          conv_go_d = 1'b1;
        end
      end
      ST_USERCAL: begin
        if (expire_i) begin
          if (second_q) begin
            load_o     = 1'b1;
            interval_o = IV_OFFSET;
            code_d     = CK_OFFSET;
            second_d   = 1'b0;
            cal_go_d   = 1'b1;
          end else begin
            state_d = ST_READY;
            code_d  = CK_FULL;
          end
        end
      end
      ST_CONVERT: begin
        if (conv_done_i) state_d = ST_READY;
      end
      default: state_d = ST_POWERUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_POWERUP;
      code_q    <= CK_FULL;
      skip_q    <= 1'b0;
      second_q  <= 1'b0;
      cal_go_q  <= 1'b0;
      conv_go_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      code_q    <= code_d;
      skip_q    <= skip_d;
      second_q  <= second_d;
      cal_go_q  <= cal_go_d;
      conv_go_q <= conv_go_d;
    end
  end

  assign busy_o     = (state_q == ST_SETTLE)  || (state_q == ST_AUTOCAL) ||
                      (state_q == ST_USERCAL) || (state_q == ST_CONVERT);
  assign cal_code_o = code_q;
  assign cal_go_o   = cal_go_q;
  assign conv_go_o  = conv_go_q;

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 128000,
  parameter int unsigned AUTO_CYC   = 128000,
  parameter int unsigned FULL_CYC   = 125000,
  parameter int unsigned OFF_CYC    = 13880,
  parameter int unsigned GAIN_CYC   = 13880
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       conv_start_i,
  input  logic       reg_wr_i,
  input  logic       reg_stcal_i,
  input  logic [1:0] reg_caltype_i,
  input  logic       conv_done_i,
  output logic       busy_o,
  output logic [1:0] cal_code_o,
  output logic       cal_go_o,
  output logic       conv_go_o
);

  localparam int unsigned MAX_CYC = max2(max2(max2(SETTLE_CYC, AUTO_CYC),
                                              max2(FULL_CYC, OFF_CYC)), GAIN_CYC);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic             load;
  logic             expire;
  interval_e        interval;
  logic [CNT_W-1:0] load_val;

  seq_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start_i (conv_start_i),
    .reg_wr_i     (reg_wr_i),
    .reg_stcal_i  (reg_stcal_i),
    .reg_kind_i   (cal_kind_e'(reg_caltype_i)),
    .conv_done_i  (conv_done_i),
    .expire_i     (expire),
    .load_o       (load),
    .interval_o   (interval),
    .busy_o       (busy_o),
    .cal_code_o   (cal_code_o),
    .cal_go_o     (cal_go_o),
    .conv_go_o    (conv_go_o)
  );

  seq_interval_rom #(
    .SETTLE_CYC (SETTLE_CYC),
    .AUTO_CYC   (AUTO_CYC),
    .FULL_CYC   (FULL_CYC),
    .OFF_CYC    (OFF_CYC),
    .GAIN_CYC   (GAIN_CYC),
    .W          (CNT_W)
  ) u_rom (
    .sel_i    (interval),
    .cycles_o (load_val)
  );

  seq_interval_timer #(
    .W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .load_val_i (load_val),
    .expire_o   (expire)
  );

endmodule

// File: rtl/adc_cal_seq_chk.sv
module adc_cal_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_start_i,
  input logic       reg_wr_i,
  input logic       busy_o,
  input logic [1:0] cal_code_o,
  input logic       cal_go_o,
  input logic       conv_go_o
);

  a_r3_no_conv_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !conv_go_o);

  a_r5_conv_go_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go_o |-> busy_o);

  a_r8_cal_go_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cal_go_o |-> busy_o);

  a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_go_o, conv_go_o}));

  a_r2_busy_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !conv_start_i && !reg_wr_i) |=> !busy_o);

  a_r9_offset_follows_gain: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_go_o && $past(busy_o)) |-> (cal_code_o == 2'b10 && $past(cal_code_o) == 2'b11));

endmodule

bind adc_cal_seq adc_cal_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_start_i (conv_start_i),
  .reg_wr_i     (reg_wr_i),
  .busy_o       (busy_o),
  .cal_code_o   (cal_code_o),
  .cal_go_o     (cal_go_o),
  .conv_go_o    (conv_go_o)
);

// File: tb/adc_cal_seq_test.sv
module adc_cal_seq_test;

  localparam int SETTLE = 40;
  localparam int AUTO   = 50;
  localparam int FULL   = 30;
  localparam int OFFS   = 12;
  localparam int GAIN   = 10;

  localparam int K_CAL  = 0;
  localparam int K_CONV = 1;
  localparam int K_END  = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       conv_start_i, reg_wr_i, reg_stcal_i, conv_done_i;
  logic [1:0] reg_caltype_i;
  logic       busy_o, cal_go_o, conv_go_o;
  logic [1:0] cal_code_o;

  typedef struct {
    int         kind;
    logic [1:0] code;
    int         len;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   run      = 0;

  always #2 clk = ~clk;

  adc_cal_seq #(
    .SETTLE_CYC (SETTLE),
    .AUTO_CYC   (AUTO),
    .FULL_CYC   (FULL),
    .OFF_CYC    (OFFS),
    .GAIN_CYC   (GAIN)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .conv_start_i  (conv_start_i),
    .reg_wr_i      (reg_wr_i),
    .reg_stcal_i   (reg_stcal_i),
    .reg_caltype_i (reg_caltype_i),
    .conv_done_i   (conv_done_i),
    .busy_o        (busy_o),
    .cal_code_o    (cal_code_o),
    .cal_go_o      (cal_go_o),
    .conv_go_o     (conv_go_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic expect_item(input int kind, input logic [1:0] code, input int len, input string req);
    exp_t e;
    e.kind = kind; e.code = code; e.len = len; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: pop the expected event for every strobe and every busy interval end.
  task automatic observe(input int kind, input logic [1:0] code, input int len);
    exp_t e;
    if (q.size() == 0) begin
      n_checks++; n_fail++;
      $display("FAIL unexpected event: actual kind %0d code %0d len %0d expected none", kind, code, len);
    end else begin
      e = q.pop_front();
      if (e.kind == K_CAL)
        check(kind == K_CAL && code == e.code, e.req, kind * 10 + code, K_CAL * 10 + e.code);
      else if (e.kind == K_CONV)
        check(kind == K_CONV, e.req, kind, K_CONV);
      else
        check(kind == K_END && len == e.len, e.req, (kind == K_END) ? len : -kind, e.len);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) run = 0;
    else begin
      if (cal_go_o)  observe(K_CAL, cal_code_o, 0);
      if (conv_go_o) observe(K_CONV, 2'b00, 0);
      if (busy_o) run++;
      else if (run > 0) begin
        observe(K_END, 2'b00, run);
        run = 0;
      end
    end
  end

  task automatic apply_reset();
    rst_n = 1'b0;
    conv_start_i = 1'b0; reg_wr_i = 1'b0; reg_stcal_i = 1'b0;
    reg_caltype_i = 2'b00; conv_done_i = 1'b0;
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && cal_go_o == 1'b0 && conv_go_o == 1'b0 && cal_code_o == 2'b00,
          "R1 in reset", {busy_o, cal_go_o, conv_go_o, cal_code_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 1'b0 && cal_go_o == 1'b0 && conv_go_o == 1'b0 && cal_code_o == 2'b00,
          "R1 after release", {busy_o, cal_go_o, conv_go_o, cal_code_o}, 0);
  endtask

  task automatic pulse_conv();
    @(negedge clk); conv_start_i = 1'b1;
    @(negedge clk); conv_start_i = 1'b0;
  endtask

  task automatic write_reg(input logic stcal, input logic [1:0] kind);
    @(negedge clk); reg_wr_i = 1'b1; reg_stcal_i = stcal; reg_caltype_i = kind;
    @(negedge clk); reg_wr_i = 1'b0; reg_stcal_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic do_conv(input int lat, input string req);
    expect_item(K_CONV, 2'b00, 0, req);
    expect_item(K_END, 2'b00, lat, req);
    pulse_conv();
    repeat (lat - 1) @(negedge clk);
    conv_done_i = 1'b1;
    @(negedge clk); conv_done_i = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (2) @(negedge clk);
    check(q.size() == 0, req, q.size(), 0);
  endtask

  initial begin
    // Sequence 1: regular power-up path, then user calibrations.
    apply_reset();
    expect_item(K_END, 2'b00, SETTLE, "R2 settle length");
    pulse_conv();
    repeat (5) @(negedge clk);
    pulse_conv();                      // R3 dropped during settle
    repeat (5) @(negedge clk);
    pulse_conv();
    wait_idle();

    expect_item(K_CAL, 2'b00, 0, "R4 auto cal code");
    expect_item(K_END, 2'b00, AUTO, "R7 auto cal not aborted");
    pulse_conv();
    repeat (3) @(negedge clk);
    write_reg(1'b1, 2'b10);            // R7 / R10 write during auto cal
    pulse_conv();                      // R3
    wait_idle();

    do_conv(4, "R5 conversion");
    do_conv(7, "R5 conversion long");

    expect_item(K_CAL, 2'b00, 0, "R8 full code");
    expect_item(K_END, 2'b00, FULL, "R8 full length");
    write_reg(1'b1, 2'b00);
    repeat (3) @(negedge clk);
    pulse_conv();                      // R3
    write_reg(1'b1, 2'b11);            // R10
    wait_idle();

    expect_item(K_CAL, 2'b10, 0, "R8 offset code");
    expect_item(K_END, 2'b00, OFFS, "R8 offset length");
    write_reg(1'b1, 2'b10);
    write_reg(1'b1, 2'b00);            // R10
    wait_idle();

    expect_item(K_CAL, 2'b11, 0, "R8 gain code");
    expect_item(K_END, 2'b00, GAIN, "R10 gain length with write");
    write_reg(1'b1, 2'b11);
    write_reg(1'b1, 2'b01);            // R10
    wait_idle();

    expect_item(K_CAL, 2'b11, 0, "R9 gain phase first");
    expect_item(K_CAL, 2'b10, 0, "R9 offset phase second");
    expect_item(K_END, 2'b00, GAIN + OFFS, "R9 total length");
    write_reg(1'b1, 2'b01);
    wait_idle();

    expect_item(K_CAL, 2'b11, 0, "R11 calibration wins");
    expect_item(K_END, 2'b00, GAIN, "R11 length");
    @(negedge clk);
    conv_start_i = 1'b1; reg_wr_i = 1'b1; reg_stcal_i = 1'b1; reg_caltype_i = 2'b11;
    @(negedge clk);
    conv_start_i = 1'b0; reg_wr_i = 1'b0; reg_stcal_i = 1'b0;
    wait_idle();

    write_reg(1'b0, 2'b00);
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R8 write without start bit", busy_o, 0);
    do_conv(3, "R8 idle after plain write");
    drain("R8 sequence one complete");

    // Sequence 2: write before the first pulse cancels the auto calibration.
    apply_reset();
    write_reg(1'b0, 2'b01);
    expect_item(K_END, 2'b00, SETTLE, "R6 settle kept");
    pulse_conv();
    wait_idle();
    do_conv(5, "R6 converts after early write");
    drain("R6 sequence two complete");

    // Sequence 3: write during the settle window.
    apply_reset();
    expect_item(K_END, 2'b00, SETTLE, "R6 settle not shortened");
    pulse_conv();
    repeat (10) @(negedge clk);
    write_reg(1'b1, 2'b00);
    wait_idle();
    do_conv(2, "R6 converts after settle write");
    drain("R6 sequence three complete");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule